// File: doc/BRIEF.md
# Byte-Lane Banked Memory

This block is a byte-addressable memory that is 32 bits wide. It is built from four independent byte-wide banks. Any access of one, two or four bytes completes in a single request, even when the start address is not a multiple of four. Each bank decodes the byte address on its own. A bank either uses the shared word index or the index one above it, so a word that straddles two rows is fetched in one access and not in two.

On a write, the incoming data is rotated left by the byte offset, and only the lanes the access covers are enabled. On a read, the four bank outputs are registered. The byte offset and the size are registered beside them, and the data is rotated right so that the addressed byte lands in the lowest byte of the result. An access that runs past the last row continues at row zero, and one cycle later it raises a boundary flag.

Top module: `byte_lane_mem`

## Requirements
- R1: The byte at address a is held in bank a mod 4. An aligned 4-byte read returns bytes a, a+1, a+2 and a+3 in bits 7:0, 15:8, 23:16 and 31:24.
- R2: An unaligned 4-byte read returns bytes a to a+3 in a single access, with byte a in bits 7:0.
- R3: The banks whose lane number is below the byte offset use the word index plus one. At offset 3, the banks for lanes 0 to 2 therefore read the following row.
- R4: Read data and rvalid_o appear in the cycle after the request. rvalid_o is high only after a read request.
- R5: size_i encodes the access length: 00 is 1 byte, 01 is 2 bytes, and 10 and 11 are 4 bytes. A write changes exactly the bytes from a to a+length-1 and leaves all other bytes unchanged.
- R6: A read does not change the contents of memory.
- R7: In read data, the bytes at or above the access length are zero.
- R8: The last row of memory is row 2^WORD_W-1. An access that starts in that row and has offset+length greater than 4 continues at row 0. wrap_o is high in the following cycle for such an access, and low for every other access.
- R9: While rst_ni is low, and after it rises, rvalid_o and wrap_o stay 0 until the first request, and rdata_o stays 0.
- R10: A cycle with req_i low writes nothing, and in the next cycle rvalid_o is 0 and rdata_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | WORD_W+2 | Byte address |
| size_i | input | 2 | Access length code |
| wdata_i | input | 32 | Write data, first byte in bits 7:0 |
| rdata_o | output | 32 | Read data, first byte in bits 7:0 |
| rvalid_o | output | 1 | Read data valid |
| wrap_o | output | 1 | Previous access wrapped past the last row |

## Verification
The hardest case to reach is an access that wraps at the top of memory. It needs the last row, a nonzero offset and a length that carries past lane 3, all at once, and only then do the low lanes select row 0. The stimulus first fills the whole memory with a known pattern. It then writes and reads words at byte addresses 1021 and 1022, and reads row 0 back to confirm where the wrapped bytes landed. Byte and word accesses that end exactly at address 1023 check that wrap_o stays low when the access does not cross.

// File: rtl/bl_mem_pkg.sv
package bl_mem_pkg;
  localparam int LANE_W = 8;

  typedef logic [1:0] size_t;
  localparam size_t SZ_BYTE = 2'd0;
  localparam size_t SZ_HALF = 2'd1;

  // Codes 2 and 3 both select a full-width access.
  function automatic int size_bytes(size_t s, int lanes);
    case (s)
      SZ_BYTE: return 1;
      SZ_HALF: return 2;
      default: return lanes;
    endcase
  endfunction
endpackage

// File: rtl/bl_lane_map.sv
module bl_lane_map
  import bl_mem_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int WORD_W    = 8,
  localparam int OFF_W    = $clog2(NUM_LANES),
  localparam int ADDR_W   = WORD_W + OFF_W,
  localparam int DATA_W   = NUM_LANES * LANE_W
) (
  input  logic                                req_i,
  input  logic                                we_i,
  input  logic [ADDR_W-1:0]                   addr_i,
  input  size_t                               size_i,
  input  logic [DATA_W-1:0]                   wdata_i,
  output logic [NUM_LANES-1:0][WORD_W-1:0]    lane_idx_o,
  output logic [NUM_LANES-1:0]                lane_we_o,
  output logic [NUM_LANES-1:0][LANE_W-1:0]    lane_wdata_o,
  output logic                                cross_top_o
);
  logic [WORD_W-1:0] base;
  logic [OFF_W-1:0]  off;
  logic [OFF_W-1:0]  pos;
  logic [OFF_W:0]    nbytes;

  always_comb begin
    base   = addr_i[ADDR_W-1:OFF_W];
    off    = addr_i[OFF_W-1:0];
    nbytes = (OFF_W+1)'(size_bytes(size_i, NUM_LANES));
    cross_top_o = req_i && (base == '1) &&
                  (({1'b0, off} + nbytes) > (OFF_W+1)'(NUM_LANES));
    pos = '0;
    for (int k = 0; k < NUM_LANES; k++) begin
      pos             = OFF_W'(k) - off;  // position of lane k inside the access
      lane_idx_o[k]   = base + WORD_W'(OFF_W'(k) < off);
      lane_we_o[k]    = req_i & we_i & ({1'b0, pos} < nbytes);
      lane_wdata_o[k] = wdata_i[pos*LANE_W +: LANE_W];
    end
  end

  always_comb begin
    if (cross_top_o) p_wrap_row0_r8: assert (lane_idx_o[0] == '0);
    if (req_i && !we_i) p_read_no_we_r6: assert (lane_we_o == '0);
  end
endmodule

// File: rtl/bl_byte_bank.sv
module bl_byte_bank
  import bl_mem_pkg::*;
#(
  parameter int WORD_W  = 8,
  localparam int DEPTH  = 1 << WORD_W
) (
  input  logic              clk_i,
  input  logic              en_i,
  input  logic              we_i,
  input  logic [WORD_W-1:0] idx_i,
  input  logic [LANE_W-1:0] wdata_i,
  output logic [LANE_W-1:0] rdata_o
);
  logic [LANE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (en_i) begin
      if (we_i) mem[idx_i] <= wdata_i;
      else      rdata_o    <= mem[idx_i];
    end
  end
endmodule

// File: rtl/bl_read_align.sv
module bl_read_align
  import bl_mem_pkg::*;
#(
  parameter int NUM_LANES = 4,
  localparam int OFF_W    = $clog2(NUM_LANES),
  localparam int DATA_W   = NUM_LANES * LANE_W
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             rd_i,
  input  logic [OFF_W-1:0]                 off_i,
  input  size_t                            size_i,
  input  logic [NUM_LANES-1:0][LANE_W-1:0] lane_rdata_i,
  output logic [DATA_W-1:0]                rdata_o,
  output logic                             rvalid_o
);
  logic [OFF_W-1:0] off_q;
  size_t            size_q;
  logic             valid_q;
  logic [OFF_W-1:0] src;
  logic [OFF_W:0]   nbytes;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q   <= '0;
      size_q  <= SZ_BYTE;
      valid_q <= 1'b0;
    end else begin
      valid_q <= rd_i;
      if (rd_i) begin
        off_q  <= off_i;
        size_q <= size_i;
      end
    end
  end

  always_comb begin
    nbytes  = (OFF_W+1)'(size_bytes(size_q, NUM_LANES));
    rdata_o = '0;
    src     = '0;
    for (int j = 0; j < NUM_LANES; j++) begin
      src = OFF_W'(j) + off_q;  // rotate right by the registered offset
      if (valid_q && ((OFF_W+1)'(j) < nbytes))
        rdata_o[j*LANE_W +: LANE_W] = lane_rdata_i[src];
    end
  end

  assign rvalid_o = valid_q;
endmodule

// File: rtl/byte_lane_mem.sv
module byte_lane_mem
  import bl_mem_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int WORD_W    = 8,
  localparam int OFF_W    = $clog2(NUM_LANES),
  localparam int ADDR_W   = WORD_W + OFF_W,
  localparam int DATA_W   = NUM_LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              wrap_o
);
  logic [NUM_LANES-1:0][WORD_W-1:0] lane_idx;
  logic [NUM_LANES-1:0]             lane_we;
  logic [NUM_LANES-1:0][LANE_W-1:0] lane_wdata;
  logic [NUM_LANES-1:0][LANE_W-1:0] lane_rdata;
  logic                             cross_top;
  logic                             wrap_q;
  logic                             rd_req;

  assign rd_req = req_i & ~we_i;

  bl_lane_map #(.NUM_LANES(NUM_LANES), .WORD_W(WORD_W)) u_map (
    .req_i        (req_i),
    .we_i         (we_i),
    .addr_i       (addr_i),
    .size_i       (size_i),
    .wdata_i      (wdata_i),
    .lane_idx_o   (lane_idx),
    .lane_we_o    (lane_we),
    .lane_wdata_o (lane_wdata),
    .cross_top_o  (cross_top)
  );

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_bank
    bl_byte_bank #(.WORD_W(WORD_W)) u_bank (
      .clk_i   (clk_i),
      .en_i    (rd_req | lane_we[k]),
      .we_i    (lane_we[k]),
      .idx_i   (lane_idx[k]),
      .wdata_i (lane_wdata[k]),
      .rdata_o (lane_rdata[k])
    );
  end

  bl_read_align #(.NUM_LANES(NUM_LANES)) u_align (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rd_i         (rd_req),
    .off_i        (addr_i[OFF_W-1:0]),
    .size_i       (size_i),
    .lane_rdata_i (lane_rdata),
    .rdata_o      (rdata_o),
    .rvalid_o     (rvalid_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wrap_q <= 1'b0;
    else         wrap_q <= cross_top;
  end
  assign wrap_o = wrap_q;

  p_rvalid_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o == $past(req_i && !we_i));
  p_write_lanes_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i) |-> ($countones(lane_we) == size_bytes(size_i, NUM_LANES)));
  p_wrap_after_req_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |-> $past(req_i));
  p_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> (!rvalid_o && !wrap_o));
endmodule

// File: tb/byte_lane_mem_bench.sv
`timescale 1ns/1ps
module byte_lane_mem_bench;
  localparam int AW  = 10;
  localparam int MEM = 1 << AW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [1:0]  size = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;
  logic        wrap;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] model [MEM];

  always #2 clk = ~clk;

  byte_lane_mem u_byte_lane_mem (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .size_i(size), .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid), .wrap_o(wrap)
  );

  typedef struct packed {
    logic        we;
    logic [9:0]  addr;
    logic [1:0]  size;
    logic [31:0] wdata;
    logic [2:0]  kind;
  } vec_t;

  localparam vec_t VEC [16] = '{
    '{1'b0, 10'h040, 2'd2, 32'h0, 3'd0},
    '{1'b0, 10'h041, 2'd2, 32'h0, 3'd1},
    '{1'b0, 10'h042, 2'd2, 32'h0, 3'd1},
    '{1'b0, 10'h043, 2'd2, 32'h0, 3'd2},
    '{1'b0, 10'h087, 2'd0, 32'h0, 3'd3},
    '{1'b0, 10'h08A, 2'd1, 32'h0, 3'd3},
    '{1'b0, 10'h08B, 2'd1, 32'h0, 3'd3},
    '{1'b1, 10'h0A5, 2'd1, 32'hFFFF_1234, 3'd4},
    '{1'b0, 10'h0A4, 2'd2, 32'h0, 3'd4},
    '{1'b1, 10'h0F3, 2'd0, 32'hFFFF_FF77, 3'd4},
    '{1'b0, 10'h0F0, 2'd2, 32'h0, 3'd4},
    '{1'b1, 10'h121, 2'd3, 32'hCAFE_F00D, 3'd4},
    '{1'b0, 10'h120, 2'd2, 32'h0, 3'd4},
    '{1'b0, 10'h124, 2'd2, 32'h0, 3'd4},
    '{1'b0, 10'h123, 2'd3, 32'h0, 3'd2},
    '{1'b0, 10'h123, 2'd3, 32'h0, 3'd5}
  };

  function automatic string tag_of(logic [2:0] k);
    case (k)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R7";
      3'd4: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int nb_of(logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
  endfunction

  // Called at a negedge; returns at the following negedge with outputs sampled.
  task automatic acc(logic w, logic [AW-1:0] a, logic [1:0] s, logic [31:0] d, string tag);
    logic [31:0] exp;
    logic        exp_wrap;
    int n;
    n = nb_of(s);
    exp = '0;
    for (int j = 0; j < n; j++) exp[j*8 +: 8] = model[(int'(a) + j) % MEM];
    exp_wrap = (a[AW-1:2] == '1) && ((int'(a[1:0]) + n) > 4);
    req = 1'b1; we = w; addr = a; size = s; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    if (w) for (int j = 0; j < n; j++) model[(int'(a) + j) % MEM] = d[j*8 +: 8];
    check("R4", 32'(rvalid), 32'(!w));
    if (!w) check(tag, rdata, exp);
    check("R8", 32'(wrap), 32'(exp_wrap));
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state, during and after reset
    check("R9", {rdata[31:2], rvalid, wrap}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", {rdata[31:2], rvalid, wrap}, 32'h0);

    for (int w = 0; w < MEM / 4; w++) begin
      logic [31:0] d;
      for (int j = 0; j < 4; j++) d[j*8 +: 8] = 8'((w*4 + j) * 7 + 3);
      acc(1'b1, AW'(w*4), 2'd2, d, "R1");
    end

    for (int i = 0; i < 16; i++)
      acc(VEC[i].we, VEC[i].addr, VEC[i].size, VEC[i].wdata, tag_of(VEC[i].kind));

    // R10: idle cycle after a read
    acc(1'b0, 10'h010, 2'd2, 32'h0, "R1");
    @(negedge clk);
    check("R10", {rdata[31:2], rvalid, wrap}, 32'h0);
    acc(1'b0, 10'h010, 2'd2, 32'h0, "R10");

    // R8: wrap across the top row
    acc(1'b1, 10'd1022, 2'd2, 32'hDDCC_BBAA, "R8");
    acc(1'b0, 10'd0, 2'd2, 32'h0, "R8");
    check("R8", rdata[15:0], 16'hDDCC);
    acc(1'b0, 10'd1021, 2'd2, 32'h0, "R8");
    acc(1'b0, 10'd1023, 2'd0, 32'h0, "R8");
    acc(1'b0, 10'd1020, 2'd2, 32'h0, "R8");
    acc(1'b0, 10'd1023, 2'd2, 32'h0, "R3");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule